// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures an incoming signal with a wrapping binary counter. In frequency mode it opens a gate of a chosen length, measured in milliseconds, and counts rising edges of the selected input while the gate is open. In period mode it counts pulses of a fixed check clock over one or two full periods of the low-range input. There are two inputs. The high-range input passes through a divide-by-two stage before it is counted. The low-range input is counted directly. Both inputs are asynchronous, so each one is synchronised and edge-detected before it is used.

A controller starts a measurement by writing a control word. The word carries an enable bit, the mode, the input select and a two-bit gate select. Once started, the block waits for a settling interval, then measures, then raises a done flag and holds the result. Writing the enable bit as 0 clears the count. Writing it as 1 again without a clear in between continues from the held value, so counts from several runs add up. The millisecond timebase and the check clock come from the system clock through two parameters: clocks per millisecond, and clocks per check pulse.

Top module: `meas_counter`

## Requirements
- R1: The result is CNT_W bits wide (20 by default). It counts modulo 2^CNT_W and wraps to zero after its all-ones value.
- R2: In frequency mode (ctl_period=0), the gate stays open for 4, 8, 32 or 64 ms when ctl_gate_sel is 0, 1, 2 or 3. The result grows by the number of counted edges seen during the gate.
- R3: After a start, the block waits before it opens the gate: 4 ms when ctl_gate_sel[1]=0 and 8 ms when ctl_gate_sel[1]=1. Edges that arrive during the wait are not counted. In frequency mode, done rises exactly (wait + gate) ms after the start.
- R4: In period mode (ctl_period=1), after the wait the block waits for a rising edge of lo_in. It then adds one count per check pulse until lo_in has completed one period (ctl_gate_sel[0]=0) or two periods (ctl_gate_sel[0]=1).
- R5: With ctl_src_hi=1 in frequency mode, the result grows by one for every second rising edge of hi_in, where rising edges are counted from the start.
- R6: A load with ctl_enable=1 starts a measurement. In the next cycle done is 0 and the result keeps its previous value, so repeated starts accumulate (integrating count).
- R7: A load with ctl_enable=0 clears the result to 0 and done to 0. Activity on the inputs then has no effect until the next start.
- R8: done rises when the measurement completes. While done is 1 and no load occurs, the result stays frozen and done stays 1.
- R9: After reset the result is 0 and done is 0.
- R10: Period mode always measures lo_in. Edges on hi_in have no effect there, whatever the value of ctl_src_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_load | input | 1 | One-cycle strobe that applies the control word |
| ctl_enable | input | 1 | 1 = start or continue counting, 0 = clear |
| ctl_period | input | 1 | 1 = period mode, 0 = frequency mode |
| ctl_src_hi | input | 1 | Frequency mode source: 1 = high-range input, 0 = low-range input |
| ctl_gate_sel | input | 2 | Gate time select, or period count in period mode |
| hi_in | input | 1 | High-range asynchronous input |
| lo_in | input | 1 | Low-range asynchronous input |
| result | output | CNT_W (20) | Measurement count |
| done | output | 1 | Measurement complete |

## Verification
The assertions assume that ctl_load is a single-cycle strobe and that the control fields are valid whenever it is high. They also assume that hi_in and lo_in are ordinary digital levels, so that each input edge can add at most one count per clock. The stimulus drives every control and input signal only on the falling clock edge. It pulses ctl_load for exactly one cycle. It toggles the inputs at fixed half-periods of one or more clocks, so the synchroniser always sees clean levels. A reduced counter width and a scaled timebase bring the wrap and the 64 ms gate within reach.

// File: rtl/meas_pkg.sv
package meas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_GATE   = 3'd2,
        ST_ARM    = 3'd3,
        ST_PERIOD = 3'd4,
        ST_DONE   = 3'd5
    } meas_state_e;

    localparam int MS_W = 7;

    // Gate length in milliseconds for each select code
    function automatic logic [MS_W-1:0] gate_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    gate_ms = 7'd4;
            2'd1:    gate_ms = 7'd8;
            2'd2:    gate_ms = 7'd32;
            default: gate_ms = 7'd64;
        endcase
    endfunction

    // Settling interval: the upper end of each wait band
    function automatic logic [MS_W-1:0] wait_ms(input logic [1:0] sel);
        wait_ms = sel[1] ? 7'd8 : 7'd4;
    endfunction

endpackage

// File: rtl/meas_edge_sync.sv
module meas_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [2:0] sh_q;
    logic [2:0] sh_d;

    always_comb begin
        sh_d = {sh_q[1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // sh_q[1] is the second synchroniser stage, sh_q[2] its delayed copy
    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/meas_timebase.sv
module meas_timebase #(
    parameter int PERIOD = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic pulse
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        if (restart)            cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q == LAST);
endmodule

// File: rtl/meas_half.sv
module meas_half (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rise,
    output logic pass
);
    logic phase_q;
    logic phase_d;

    always_comb begin
        if (clr)       phase_d = 1'b0;
        else if (rise) phase_d = ~phase_q;
        else           phase_d = phase_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    // Every second rising edge passes on
    assign pass = rise & phase_q;
endmodule

// File: rtl/meas_counter.sv
module meas_counter
    import meas_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int TICK_CYC = 36000,
    parameter int CHK_CYC  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_load,
    input  logic             ctl_enable,
    input  logic             ctl_period,
    input  logic             ctl_src_hi,
    input  logic [1:0]       ctl_gate_sel,
    input  logic             hi_in,
    input  logic             lo_in,
    output logic [CNT_W-1:0] result,
    output logic             done
);

    typedef struct packed {
        meas_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [MS_W-1:0]  left;
        logic [1:0]       per;
        logic             period;
        logic             src_hi;
        logic [1:0]       sel;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;

    logic hi_rise, lo_rise, hi_pass, ms_tick, chk_tick, edge_ok;

    meas_edge_sync u_sync_hi (.clk(clk), .rst_n(rst_n), .din(hi_in), .rise(hi_rise));
    meas_edge_sync u_sync_lo (.clk(clk), .rst_n(rst_n), .din(lo_in), .rise(lo_rise));

    meas_half u_half (
        .clk(clk), .rst_n(rst_n), .clr(ctl_load), .rise(hi_rise), .pass(hi_pass)
    );

    meas_timebase #(.PERIOD(TICK_CYC)) u_ms (
        .clk(clk), .rst_n(rst_n), .restart(ctl_load), .pulse(ms_tick)
    );

    meas_timebase #(.PERIOD(CHK_CYC)) u_chk (
        .clk(clk), .rst_n(rst_n), .restart(ctl_load), .pulse(chk_tick)
    );

    assign edge_ok = r_q.src_hi ? hi_pass : lo_rise;

    always_comb begin
        r_d = r_q;
        if (ctl_load) begin
            r_d.period = ctl_period;
            r_d.src_hi = ctl_src_hi;
            r_d.sel    = ctl_gate_sel;
            r_d.done   = 1'b0;
            if (ctl_enable) begin
                r_d.st   = ST_WAIT;
                r_d.left = wait_ms(ctl_gate_sel);
            end else begin
                r_d.st  = ST_IDLE;
                r_d.cnt = '0;
            end
        end else begin
            unique case (r_q.st)
                ST_WAIT: begin
                    if (ms_tick) begin
                        if (r_q.left == 7'd1) begin
                            if (r_q.period) begin
                                r_d.st = ST_ARM;
                            end else begin
                                r_d.st   = ST_GATE;
                                r_d.left = gate_ms(r_q.sel);
                            end
                        end else begin
                            r_d.left = r_q.left - 1'b1;
                        end
                    end
                end
                ST_GATE: begin
                    if (edge_ok) r_d.cnt = r_q.cnt + 1'b1;
                    if (ms_tick) begin
                        if (r_q.left == 7'd1) begin
                            r_d.st   = ST_DONE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.left = r_q.left - 1'b1;
                        end
                    end
                end
                ST_ARM: begin
                    if (lo_rise) begin
                        r_d.st  = ST_PERIOD;
                        r_d.per = r_q.sel[0] ? 2'd2 : 2'd1;
                    end
                end
                ST_PERIOD: begin
                    if (chk_tick) r_d.cnt = r_q.cnt + 1'b1;
                    if (lo_rise) begin
                        if (r_q.per == 2'd1) begin
                            r_d.st   = ST_DONE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.per = r_q.per - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result = r_q.cnt;
    assign done   = r_q.done;

endmodule

// File: rtl/meas_counter_sva.sv
module meas_counter_sva #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_load,
    input logic             ctl_enable,
    input logic [CNT_W-1:0] result,
    input logic             done
);

    p_start_drops_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_load && ctl_enable |=> !done);

    p_start_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_load && ctl_enable |=> result == $past(result));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_load && !ctl_enable |=> (result == '0) && !done);

    p_done_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ctl_load |=> done && $stable(result));

    p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_load |=> (result == $past(result)) || (result == $past(result) + 1'b1));

endmodule

bind meas_counter meas_counter_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_enable(ctl_enable),
    .result(result), .done(done)
);

// File: tb/meas_counter_test.sv
module meas_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 10;
    localparam int TICK = 20;
    localparam int CHK  = 3;
    localparam int MASK = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_load = 1'b0, ctl_enable = 1'b0, ctl_period = 1'b0, ctl_src_hi = 1'b0;
    logic [1:0] ctl_gate_sel = 2'd0;
    logic hi_in = 1'b0, lo_in = 1'b0;
    logic [CW-1:0] result;
    logic done;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int hi_hp = 0, lo_hp = 0, hi_ph = 0, lo_ph = 0;

    meas_counter #(.CNT_W(CW), .TICK_CYC(TICK), .CHK_CYC(CHK)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_enable(ctl_enable),
        .ctl_period(ctl_period), .ctl_src_hi(ctl_src_hi), .ctl_gate_sel(ctl_gate_sel),
        .hi_in(hi_in), .lo_in(lo_in), .result(result), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Input waveform generators, active on the falling edge
    always @(negedge clk) begin
        if (hi_hp > 0) begin
            hi_ph++;
            if (hi_ph >= hi_hp) begin hi_ph = 0; hi_in = ~hi_in; end
        end
        if (lo_hp > 0) begin
            lo_ph++;
            if (lo_ph >= lo_hp) begin lo_ph = 0; lo_in = ~lo_in; end
        end
    end

    // Behavioural reference model; m_st: 0 idle, 1 wait, 2 gate, 3 arm, 4 period, 5 done
    int m_st, m_cnt, m_left, m_per, m_tb, m_ck, m_sel;
    bit m_done, m_half, m_pmode, m_hi;
    bit hh1, hh2, hh3, lh1, lh2, lh3;
    always @(posedge clk) begin
        bit hr, lr, ms, ck, inc;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_left = 0; m_per = 0; m_tb = 0; m_ck = 0; m_sel = 0;
            m_done = 0; m_half = 0; m_pmode = 0; m_hi = 0;
            hh1 = 0; hh2 = 0; hh3 = 0; lh1 = 0; lh2 = 0; lh3 = 0;
        end else begin
            hr = hh2 && !hh3;
            lr = lh2 && !lh3;
            ms = (m_tb == TICK - 1);
            ck = (m_ck == CHK - 1);
            if (ctl_load) begin
                m_pmode = ctl_period; m_hi = ctl_src_hi; m_sel = ctl_gate_sel; m_done = 0;
                if (ctl_enable) begin m_st = 1; m_left = (m_sel >= 2) ? 8 : 4; end
                else begin m_st = 0; m_cnt = 0; end
                m_tb = 0; m_ck = 0; m_half = 0;
            end else begin
                inc = m_hi ? (hr && m_half) : lr;
                if (hr) m_half = !m_half;
                m_tb = (m_tb + 1) % TICK;
                m_ck = (m_ck + 1) % CHK;
                case (m_st)
                    1: if (ms) begin
                           if (m_left == 1) begin
                               if (m_pmode) m_st = 3;
                               else begin
                                   m_st = 2;
                                   case (m_sel) 0: m_left = 4; 1: m_left = 8; 2: m_left = 32; default: m_left = 64; endcase
                               end
                           end else m_left--;
                       end
                    2: begin
                           if (inc) m_cnt = (m_cnt + 1) & MASK;
                           if (ms) begin
                               if (m_left == 1) begin m_st = 5; m_done = 1; end
                               else m_left--;
                           end
                       end
                    3: if (lr) begin m_st = 4; m_per = (m_sel % 2) ? 2 : 1; end
                    4: begin
                           if (ck) m_cnt = (m_cnt + 1) & MASK;
                           if (lr) begin
                               if (m_per == 1) begin m_st = 5; m_done = 1; end
                               else m_per--;
                           end
                       end
                    default: ;
                endcase
            end
            hh3 = hh2; hh2 = hh1; hh1 = hi_in;
            lh3 = lh2; lh2 = lh1; lh1 = lo_in;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_st == 2)      check(result == m_cnt[CW-1:0], "R2 model result", result, m_cnt);
            else if (m_st == 4) check(result == m_cnt[CW-1:0], "R4 model result", result, m_cnt);
            else                check(result == m_cnt[CW-1:0], "R8 model result", result, m_cnt);
            check(done == m_done, "R8 model done", done, m_done);
        end
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            summary_and_end();
        end
    end

    task automatic load(input bit en, input bit pm, input bit sh, input logic [1:0] sel);
        @(negedge clk);
        ctl_load = 1'b1; ctl_enable = en; ctl_period = pm; ctl_src_hi = sh; ctl_gate_sel = sel;
        @(negedge clk);
        ctl_load = 1'b0;
    endtask

    // Returns the number of falling edges seen from the start until done
    task automatic wait_done(output int k);
        k = 1;
        while (!done && k < 5000) begin @(negedge clk); k++; end
    endtask

    function automatic bit near(input int a, input int e, input int tol);
        return (a >= e - tol) && (a <= e + tol);
    endfunction

    initial begin
        int k, v1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == 0, "R9 reset result", result, 0);
        check(done == 0, "R9 reset done", done, 0);

        // Frequency mode, low input, period 4 clocks, shortest gate
        lo_hp = 2;
        load(1, 0, 0, 2'd0);
        wait_done(k);
        check(k == (4 + 4) * TICK + 1, "R3 done timing sel0", k, (4 + 4) * TICK + 1);
        check(near(result, 20, 1), "R2 gate 4ms count", result, 20);

        load(0, 0, 0, 2'd0);
        check(result == 0 && done == 0, "R7 clear", result, 0);

        load(1, 0, 0, 2'd3);
        wait_done(k);
        check(k == (8 + 64) * TICK + 1, "R3 done timing sel3", k, (8 + 64) * TICK + 1);
        check(near(result, 320, 1), "R2 gate 64ms count", result, 320);

        // Halved high input
        load(0, 0, 0, 2'd0);
        lo_hp = 0; hi_hp = 2;
        load(1, 0, 1, 2'd1);
        wait_done(k);
        check(k == (4 + 8) * TICK + 1, "R3 done timing sel1", k, (4 + 8) * TICK + 1);
        check(near(result, 20, 1), "R5 halved high input", result, 20);

        // Period mode, one and two periods of 60 clocks
        load(0, 0, 0, 2'd0);
        hi_hp = 0; lo_hp = 30;
        load(1, 1, 0, 2'd0);
        wait_done(k);
        check(done == 1, "R4 period one done", done, 1);
        check(near(result, 20, 1), "R4 one period", result, 20);
        load(0, 0, 0, 2'd0);
        load(1, 1, 0, 2'd1);
        wait_done(k);
        check(near(result, 40, 1), "R4 two periods", result, 40);

        // Period mode ignores the high input
        load(0, 0, 0, 2'd0);
        hi_hp = 1;
        load(1, 1, 1, 2'd0);
        wait_done(k);
        check(near(result, 20, 1), "R10 period uses low input", result, 20);

        // Integrating count
        load(0, 0, 0, 2'd0);
        hi_hp = 0; lo_hp = 2;
        load(1, 0, 0, 2'd0);
        wait_done(k);
        v1 = result;
        load(1, 0, 0, 2'd0);
        check(result == v1, "R6 restart keeps count", result, v1);
        check(done == 0, "R6 restart drops done", done, 0);
        wait_done(k);
        check(near(result, v1 + 20, 2), "R6 integrated count", result, v1 + 20);

        // Frozen after done
        v1 = result;
        repeat (100) @(negedge clk);
        check(result == v1 && done == 1, "R8 frozen after done", result, v1);

        // Cleared block ignores input activity
        hi_hp = 1;
        load(0, 0, 0, 2'd0);
        repeat (100) @(negedge clk);
        check(result == 0, "R7 idle ignores inputs", result, 0);
        check(done == 0, "R7 idle done low", done, 0);

        // Wrap: two 64 ms runs at one edge per 2 clocks
        hi_hp = 0; lo_hp = 1;
        load(1, 0, 0, 2'd3);
        wait_done(k);
        check(near(result, 640, 1), "R1 first long run", result, 640);
        load(1, 0, 0, 2'd3);
        wait_done(k);
        check(near(result, 1280 - 1024, 2), "R1 wrap", result, 256);

        summary_and_end();
    end
endmodule